// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This unit gathers every interrupt source of a small 8-bit processor core and offers the core one request at a time. It has five hardware request lines. One is non-maskable and edge-qualified. One is maskable, caught on a rising edge and held in a latch. Two are maskable and level-sensitive. The last is maskable but carries no vector, so the requesting device must supply the instruction during an acknowledge cycle. A software restart request with a 3-bit number joins the same arbiter.

The winning request appears combinationally on `req_valid`, with its 16-bit target address on `req_vector`. For the non-vectored source, `req_ext` is set instead of giving an address. The core accepts the offered request by raising `core_take` for one cycle. On that clock edge the unit clears the source's pending state. If the source is maskable, the unit also drops the global enable. For the non-vectored line it pulses `ext_ack` in the following cycle. A status word returns the mask bits, the global enable and the raw pending state of the sources.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset there is no request (`req_valid`=0), `ext_ack`=0, the global enable is 0 and all three mask bits are 1, so `stat_word` reads 0x07.
- R2: A recognised `nmi_req` is offered with vector 0x0024 whatever the mask bits and the global enable hold, and it wins over every other source.
- R3: `nmi_req` is recognised only after a rising edge and only while the line is still high. If the line falls before acceptance, the request is dropped. A line that stays high after acceptance does not raise a new request.
- R4: A rising edge on `vec_hi_req` sets a pending latch, which holds even after the line falls. The latch clears when its request is accepted or when `clr_hi_pend` is pulsed. Its vector is 0x003C.
- R5: `vec_mid_req` and `vec_lo_req` are level-sensitive, with vectors 0x0034 and 0x002C. A request disappears as soon as its level falls.
- R6: A mask bit of 1 blocks its source: bit 2 blocks hi, bit 1 blocks mid and bit 0 blocks lo. A global enable of 0 blocks hi, mid, lo and `ext_req`. The mask is loaded from `mask_wdata` on a `mask_wr` cycle. The hi latch still captures edges while the source is blocked.
- R7: The priority order, from highest to lowest, is: nmi, hi, mid, lo, ext, software.
- R8: An `ext_req` request is offered with `req_ext`=1 and `req_vector`=0. When the core accepts it, `ext_ack` is 1 for exactly the one cycle after the accepting edge.
- R9: A software restart (`sw_req` with `sw_num`=n) is offered with vector n*8 and `req_ext`=0. It is not blocked by the mask or the global enable.
- R10: Accepting a hi, mid, lo or ext request clears the global enable. Acceptance wins over an `ie_set` in the same cycle. `ie_set` sets the enable and `ie_clr` clears it. Accepting an nmi or software request leaves the enable unchanged.
- R11: `stat_word` bits [2:0] hold the mask bits, bit 3 the global enable, bit 4 the level of `vec_lo_req`, bit 5 the level of `vec_mid_req`, bit 6 the hi latch and bit 7 the nmi pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, edge-qualified |
| vec_hi_req | input | 1 | Maskable vectored request, edge-latched |
| vec_mid_req | input | 1 | Maskable vectored request, level |
| vec_lo_req | input | 1 | Maskable vectored request, level |
| ext_req | input | 1 | Maskable non-vectored request, level |
| sw_req | input | 1 | Software restart request |
| sw_num | input | 3 | Software restart number |
| mask_wr | input | 1 | Load mask from mask_wdata |
| mask_wdata | input | 3 | New mask bits {hi, mid, lo} |
| ie_set | input | 1 | Set global enable |
| ie_clr | input | 1 | Clear global enable |
| clr_hi_pend | input | 1 | Clear the hi pending latch |
| core_take | input | 1 | Core accepts the offered request |
| req_valid | output | 1 | A request is offered |
| req_vector | output | 16 | Target address of the offered request |
| req_ext | output | 1 | Offered request needs an acknowledge cycle |
| ext_ack | output | 1 | Acknowledge pulse for the non-vectored source |
| stat_word | output | 8 | Mask, enable and raw pending state |

## Verification
The bench raises the non-maskable line and holds it high past acceptance. A design that re-arms on the level would offer the request a second time. It also drops the line before acceptance, to expose a design that serves a stale edge. It pulses the edge-latched line while that source is masked. A design that gates the latch with the mask would lose the event, and one that clears the latch on the falling edge would lose the request. The remaining tests stack several sources at once to show a swapped priority or a wrong vector, and they check that the enable drop wins over a simultaneous set. They also check that software restarts pass a cleared enable, and that the acknowledge pulse is a single cycle long.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W  = 16;
  localparam int NUM_W  = 3;
  localparam int MASK_W = 3;
  localparam int NSRC   = 6;
  localparam int IDX_W  = $clog2(NSRC);

  // index order is priority order, index 0 highest
  typedef enum logic [2:0] {
    SRC_NMI  = 3'd0,
    SRC_HI   = 3'd1,
    SRC_MID  = 3'd2,
    SRC_LO   = 3'd3,
    SRC_EXT  = 3'd4,
    SRC_SW   = 3'd5,
    SRC_NONE = 3'd7
  } src_e;

  function automatic logic [VEC_W-1:0] vec_for(src_e s, logic [NUM_W-1:0] n);
    logic [VEC_W-1:0] v;
    case (s)
      SRC_NMI: v = VEC_W'(16'h0024);
      SRC_HI:  v = VEC_W'(16'h003C);
      SRC_MID: v = VEC_W'(16'h0034);
      SRC_LO:  v = VEC_W'(16'h002C);
      SRC_SW:  v = VEC_W'(n) << 3;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic is_maskable(src_e s);
    return (s == SRC_HI) || (s == SRC_MID) || (s == SRC_LO) || (s == SRC_EXT);
  endfunction
endpackage

// File: rtl/irq_edge_catch.sv
module irq_edge_catch #(
  parameter bit HOLD_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic clr,
  output logic pend_o,
  output logic fire_o
);
  logic prev_q, pend_q;
  logic rise;
  logic drop;

  assign rise = req_in & ~prev_q;

  generate
    if (HOLD_LEVEL) begin : g_qualified
      assign drop   = ~req_in;
      assign fire_o = pend_q & req_in;
    end else begin : g_sticky
      assign drop   = 1'b0;
      assign fire_o = pend_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= req_in;
      if (clr || drop) pend_q <= 1'b0;
      else if (rise)   pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R3/R4: a fresh edge without clear or drop is captured
  a_r4_edge_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr && req_in) |=> pend_o);
  // R4: sticky latch keeps its state until cleared
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!HOLD_LEVEL && pend_o && !clr) |=> pend_o);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req,
  output logic [NSRC-1:0]  grant,
  output src_e             win
);
  always_comb begin
    grant = '0;
    win   = SRC_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        win = src_e'(i[2:0]);
      end
    end
  end

  // R7: never more than one winner, and a winner whenever someone asks
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((req != '0) == (grant != '0)));
  // R7: the granted source is always a requester
  a_r7_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              took_maskable,
  output logic [MASK_W-1:0] mask_o,
  output logic              ie_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '1;
      ie_o   <= 1'b0;
    end else begin
      if (mask_wr) mask_o <= mask_wdata;
      if (took_maskable || ie_clr) ie_o <= 1'b0;
      else if (ie_set)             ie_o <= 1'b1;
    end
  end

  // R10: acceptance of a maskable source always leaves the enable clear
  a_r10_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    took_maskable |=> !ie_o);
  // R6: mask only changes on a write
  a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_o));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req,
  input  logic              vec_hi_req,
  input  logic              vec_mid_req,
  input  logic              vec_lo_req,
  input  logic              ext_req,
  input  logic              sw_req,
  input  logic [NUM_W-1:0]  sw_num,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              clr_hi_pend,
  input  logic              core_take,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_vector,
  output logic              req_ext,
  output logic              ext_ack,
  output logic [7:0]        stat_word
);
  logic [MASK_W-1:0] mask;
  logic              ie;
  logic              nmi_pend, nmi_fire, hi_pend, hi_fire;
  logic [NSRC-1:0]   req_vec, grant;
  src_e              win;
  logic              accept;
  logic              took_maskable;

  assign accept        = core_take & req_valid;
  assign took_maskable = accept & is_maskable(win);

  irq_edge_catch #(.HOLD_LEVEL(1'b1)) u_nmi (
    .clk(clk), .rst_n(rst_n), .req_in(nmi_req),
    .clr(accept && win == SRC_NMI), .pend_o(nmi_pend), .fire_o(nmi_fire));

  irq_edge_catch #(.HOLD_LEVEL(1'b0)) u_hi (
    .clk(clk), .rst_n(rst_n), .req_in(vec_hi_req),
    .clr((accept && win == SRC_HI) || clr_hi_pend),
    .pend_o(hi_pend), .fire_o(hi_fire));

  irq_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ie_set(ie_set), .ie_clr(ie_clr), .took_maskable(took_maskable),
    .mask_o(mask), .ie_o(ie));

  always_comb begin
    req_vec          = '0;
    req_vec[SRC_NMI] = nmi_fire;
    req_vec[SRC_HI]  = hi_fire     & ie & ~mask[2];
    req_vec[SRC_MID] = vec_mid_req & ie & ~mask[1];
    req_vec[SRC_LO]  = vec_lo_req  & ie & ~mask[0];
    req_vec[SRC_EXT] = ext_req     & ie;
    req_vec[SRC_SW]  = sw_req;
  end

  irq_prio_pick u_pick (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .grant(grant), .win(win));

  assign req_valid  = (grant != '0);
  assign req_vector = vec_for(win, sw_num);
  assign req_ext    = (win == SRC_EXT);

  always_ff @(posedge clk) begin
    if (!rst_n) ext_ack <= 1'b0;
    else        ext_ack <= accept && (win == SRC_EXT);
  end

  assign stat_word = {nmi_pend, hi_pend, vec_mid_req, vec_lo_req, ie, mask};

  // R2: a live non-maskable request always owns the output
  a_r2_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fire |-> (req_valid && req_vector == 16'h0024 && !req_ext));
  // R6: a masked hi source never shows its vector
  a_r6_hi_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[2] && !nmi_fire) |-> (req_vector != 16'h003C));
  // R8: acknowledge follows acceptance of the non-vectored source
  a_r8_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ext) |=> ext_ack);
  // R8: acknowledge lasts a single cycle
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |=> !ext_ack);
endmodule

// File: tb/tb_irq_prio_unit.sv
module tb_irq_prio_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic nmi_req, vec_hi_req, vec_mid_req, vec_lo_req, ext_req, sw_req;
  logic [2:0] sw_num, mask_wdata;
  logic mask_wr, ie_set, ie_clr, clr_hi_pend, core_take;
  logic req_valid, req_ext, ext_ack;
  logic [15:0] req_vector;
  logic [7:0] stat_word;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_unit dut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .vec_hi_req(vec_hi_req),
    .vec_mid_req(vec_mid_req), .vec_lo_req(vec_lo_req), .ext_req(ext_req),
    .sw_req(sw_req), .sw_num(sw_num), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ie_set(ie_set), .ie_clr(ie_clr), .clr_hi_pend(clr_hi_pend),
    .core_take(core_take), .req_valid(req_valid), .req_vector(req_vector),
    .req_ext(req_ext), .ext_ack(ext_ack), .stat_word(stat_word));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // offered request: {valid, ext, vector}
  function automatic logic [31:0] offer();
    return {14'd0, req_valid, req_ext, req_vector};
  endfunction

  function automatic logic [31:0] exp_vec(logic [15:0] v);
    return {14'd0, 1'b1, 1'b0, v};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    {nmi_req, vec_hi_req, vec_mid_req, vec_lo_req, ext_req, sw_req} = '0;
    sw_num = '0; mask_wdata = '0;
    {mask_wr, ie_set, ie_clr, clr_hi_pend, core_take} = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 valid", {31'd0, req_valid}, 0);
    check("R1 ack", {31'd0, ext_ack}, 0);
    check("R1 status", {24'd0, stat_word}, 32'h07);
  endtask

  task automatic t_nmi();
    nmi_req = 1'b1; step();
    check("R2 nmi offered under mask", offer(), exp_vec(16'h0024));
    core_take = 1'b1; step(); core_take = 1'b0;
    check("R3 held level no retrigger", {31'd0, req_valid}, 0);
    check("R10 nmi keeps enable", {31'd0, stat_word[3]}, 0);
    nmi_req = 1'b0; step();
    nmi_req = 1'b1; step();
    nmi_req = 1'b0; step();
    check("R3 dropped before accept", {31'd0, req_valid}, 0);
    check("R11 nmi latch cleared", {31'd0, stat_word[7]}, 0);
  endtask

  task automatic t_hi();
    vec_hi_req = 1'b1; step(); vec_hi_req = 1'b0; step();
    check("R6 hi masked", {31'd0, req_valid}, 0);
    check("R11 status hi latched under mask", {24'd0, stat_word}, 32'h47);
    mask_wr = 1'b1; mask_wdata = 3'b000; ie_set = 1'b1; step();
    mask_wr = 1'b0; ie_set = 1'b0;
    check("R4 hi latched after level low", offer(), exp_vec(16'h003C));
    check("R11 status enabled", {24'd0, stat_word}, 32'h48);
    core_take = 1'b1; step(); core_take = 1'b0;
    check("R10 hi accept drops enable", {24'd0, stat_word}, 32'h00);
    ie_set = 1'b1; step(); ie_set = 1'b0;
    vec_hi_req = 1'b1; step(); vec_hi_req = 1'b0;
    check("R4 hi second edge", offer(), exp_vec(16'h003C));
    clr_hi_pend = 1'b1; step(); clr_hi_pend = 1'b0;
    check("R4 software clear", {31'd0, req_valid}, 0);
    check("R10 clear keeps enable", {31'd0, stat_word[3]}, 1);
  endtask

  task automatic t_levels();
    vec_mid_req = 1'b1; step();
    check("R5 mid vector", offer(), exp_vec(16'h0034));
    check("R11 mid level bit", {24'd0, stat_word}, 32'h28);
    vec_mid_req = 1'b0; step();
    check("R5 mid gone", {31'd0, req_valid}, 0);
    vec_lo_req = 1'b1; step();
    check("R5 lo vector", offer(), exp_vec(16'h002C));
    mask_wr = 1'b1; mask_wdata = 3'b001; step(); mask_wr = 1'b0;
    check("R6 lo masked", {31'd0, req_valid}, 0);
    mask_wr = 1'b1; mask_wdata = 3'b000; step(); mask_wr = 1'b0;
    check("R6 lo unmasked", offer(), exp_vec(16'h002C));
    vec_lo_req = 1'b0; step();
  endtask

  task automatic t_prio();
    ext_req = 1'b1; vec_lo_req = 1'b1; vec_mid_req = 1'b1;
    sw_req = 1'b1; sw_num = 3'd5; step();
    check("R7 mid over lo ext sw", offer(), exp_vec(16'h0034));
    vec_hi_req = 1'b1; step();
    check("R7 hi over mid", offer(), exp_vec(16'h003C));
    nmi_req = 1'b1; step();
    check("R7 nmi over hi", offer(), exp_vec(16'h0024));
    nmi_req = 1'b0; step();
    check("R7 hi after nmi drop", offer(), exp_vec(16'h003C));
    core_take = 1'b1; step(); core_take = 1'b0; vec_hi_req = 1'b0;
    check("R9 sw passes cleared enable", offer(), exp_vec(16'h0028));
    ie_set = 1'b1; step(); ie_set = 1'b0;
    check("R7 mid again", offer(), exp_vec(16'h0034));
    vec_mid_req = 1'b0; step();
    check("R7 lo next", offer(), exp_vec(16'h002C));
    vec_lo_req = 1'b0; step();
    check("R8 ext offer", offer(), {14'd0, 1'b1, 1'b1, 16'h0000});
    ext_req = 1'b0; step();
    check("R7 sw last", offer(), exp_vec(16'h0028));
    sw_req = 1'b0; step();
  endtask

  task automatic t_ext();
    ext_req = 1'b1; step();
    core_take = 1'b1; step(); core_take = 1'b0;
    check("R8 ack after accept", {31'd0, ext_ack}, 1);
    check("R6 ext blocked by cleared enable", {31'd0, req_valid}, 0);
    step();
    check("R8 ack one cycle", {31'd0, ext_ack}, 0);
    ext_req = 1'b0; step();
  endtask

  task automatic t_sw();
    mask_wr = 1'b1; mask_wdata = 3'b111; step(); mask_wr = 1'b0;
    for (int n = 0; n < 8; n++) begin
      sw_req = 1'b1; sw_num = 3'(n); step();
      check("R9 sw vector", offer(), exp_vec(16'(n * 8)));
    end
    ie_set = 1'b1; step(); ie_set = 1'b0;
    core_take = 1'b1; step(); core_take = 1'b0; sw_req = 1'b0;
    check("R10 sw accept keeps enable", {31'd0, stat_word[3]}, 1);
    mask_wr = 1'b1; mask_wdata = 3'b000; vec_lo_req = 1'b1; step(); mask_wr = 1'b0;
    core_take = 1'b1; ie_set = 1'b1; step(); core_take = 1'b0; ie_set = 1'b0;
    check("R10 accept beats set", {31'd0, stat_word[3]}, 0);
    vec_lo_req = 1'b0;
    ie_set = 1'b1; step(); ie_set = 1'b0;
    ie_clr = 1'b1; step(); ie_clr = 1'b0;
    check("R10 ie_clr", {31'd0, stat_word[3]}, 0);
  endtask

  initial begin
    t_reset();
    t_nmi();
    t_hi();
    t_levels();
    t_prio();
    t_ext();
    t_sw();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule